// File: doc/BRIEF.md
# Restartable masked gather sequencer

The block loads up to sixteen 32-bit elements from memory into a destination vector. Each element's address is a common base address plus that lane's offset scaled by four. A lane mask chooses which lanes take part. Memory is reached through a simple line port: each request names one 64-byte line, and the response in the same handshake cycle carries the whole line plus a fault flag.

In each cycle the block takes the lowest-numbered lane that is still pending and requests the line that lane needs. When the line arrives, every pending lane that falls in that line is finished in one step: its element is taken out of the line, its destination word is written, and its mask bit is cleared. The mask is therefore the only record of progress. If a response reports a fault, the block stops, raises `fault` with `done`, and returns a mask that still holds exactly the unfinished lanes. A caller handles the fault and then issues the same gather again, passing the returned mask and destination. The new run then loads only the lanes that were left.

Top module: `gather_seq`

## Requirements
- R1: A `start` pulse is taken only while the block is idle (busy and done both low). It captures `base_addr`, `offsets`, `mask_in` and `dst_in`. A `start` pulse seen while busy has no effect on the running gather or on its result.
- R2: Lane i's byte address is `base_addr + 4*offsets[i]`, modulo 2^32. Its line number is address bits [31:6]. Address bits [5:2] give the word index k, and the element is `rsp_data[32*k +: 32]`. `base_addr[1:0]` is 0.
- R3: While busy, `req_line` is the line number of the lowest-numbered lane whose `mask_out` bit is still set.
- R4: On a handshake (`req_valid && req_ready`) with `rsp_fault` low, every pending lane that lies in the requested line is completed in that cycle: its `mask_out` bit clears and its `dst_out` word takes the element. A gather therefore makes exactly one request per distinct line among its masked lanes.
- R5: Lanes whose mask bit is clear at start, and lanes not yet completed, keep the value given on `dst_in`.
- R6: When the last pending lane completes, `done` is high for exactly one cycle, in the cycle after the final handshake. At that point `fault` is low and `mask_out` is all zeros.
- R7: On a handshake with `rsp_fault` high, no lane completes. In the next cycle `done` and `fault` are both high, and `mask_out` still holds exactly the lanes not yet done.
- R8: Starting again with the returned `mask_out` and `dst_out` finishes only the remaining lanes. It requests only their lines, and the final destination matches a fault-free run.
- R9: A start with an all-zero mask gives `done` in the next cycle and makes no request.
- R10: Once `req_valid` is high with `req_ready` low, `req_valid` and `req_line` hold until the handshake.
- R11: After reset, `busy`, `done`, `fault` and `req_valid` are low, and `mask_out` and `dst_out` are zero. `busy` is high from the cycle after an accepted start until the final handshake, and `busy` and `done` are never high together. `req_valid` is high only while busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start | input | 1 | Begin a gather (taken when idle) |
| base_addr | input | ADDR_W | Byte base address, element aligned |
| offsets | input | LANES*OFF_W | Per-lane element offsets, lane i at [i*OFF_W +: OFF_W] |
| mask_in | input | LANES | Lanes to load |
| dst_in | input | LANES*ELEM_W | Initial destination vector |
| busy | output | 1 | Gather in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Gather stopped on a faulting line (valid with done) |
| mask_out | output | LANES | Lanes still pending |
| dst_out | output | LANES*ELEM_W | Destination vector |
| req_valid | output | 1 | Line request valid |
| req_line | output | ADDR_W-6 | Requested line number |
| req_ready | input | 1 | Memory accepts the request; response valid this cycle |
| rsp_data | input | 512 | Whole line, word k at [32*k +: 32] |
| rsp_fault | input | 1 | The requested line faults |

## Verification
The hardest case to reach from the ports is a fault that arrives after some lanes sharing other lines have already completed, followed by a stall pattern on the line port. The mask must then be partly cleared, and the reissue must skip exactly the lanes already done. The stimulus sweeps hundreds of pseudo-random gathers. Offsets are packed into a few lines so that lanes share lines unevenly, and the faulting line is picked as the line of a random lane, so it may come first, in the middle or last. `req_ready` patterns include constant, alternating and random stalls. Each faulted gather is immediately reissued from the returned mask and destination and checked against values computed in the bench.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    GS_IDLE = 2'd0,
    GS_RUN  = 2'd1,
    GS_FIN  = 2'd2
  } gs_state_e;
endpackage

// File: rtl/gs_lane_addr.sv
// Per-lane element address: splits into line number and word index.
module gs_lane_addr #(
  parameter int LANES  = 16,
  parameter int EA_W   = 30,
  parameter int OFF_W  = 16,
  parameter int WSEL_W = 4,
  localparam int LINE_W = EA_W - WSEL_W
) (
  input  logic [EA_W-1:0]                base_el,
  input  logic [LANES-1:0][OFF_W-1:0]    offs,
  output logic [LANES-1:0][LINE_W-1:0]   lane_line,
  output logic [LANES-1:0][WSEL_W-1:0]   lane_word
);
  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [EA_W-1:0] ea;
    assign ea           = base_el + EA_W'(offs[i]);
    assign lane_line[i] = ea[EA_W-1:WSEL_W];
    assign lane_word[i] = ea[WSEL_W-1:0];
  end
endmodule

// File: rtl/gs_first_lane.sv
// Lowest set bit of the pending mask.
module gs_first_lane #(
  parameter int LANES = 16,
  localparam int IDX_W = $clog2(LANES)
) (
  input  logic [LANES-1:0] pend,
  output logic [IDX_W-1:0] first_idx,
  output logic             any_pend
);
  always_comb begin
    first_idx = '0;
    any_pend  = 1'b0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pend[i]) begin
        first_idx = IDX_W'(i);
        any_pend  = 1'b1;
      end
    end
  end
endmodule

// File: rtl/gs_line_match.sv
// Pending lanes whose line equals the target line.
module gs_line_match #(
  parameter int LANES  = 16,
  parameter int LINE_W = 26
) (
  input  logic [LANES-1:0][LINE_W-1:0] lane_line,
  input  logic [LINE_W-1:0]            target,
  input  logic [LANES-1:0]             pend,
  output logic [LANES-1:0]             hit
);
  for (genvar i = 0; i < LANES; i++) begin : g_cmp
    assign hit[i] = pend[i] & (lane_line[i] == target);
  end
endmodule

// File: rtl/gs_word_pick.sv
// Selects each lane's element from the returned line.
module gs_word_pick #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 32,
  parameter int WORDS  = 16,
  localparam int WSEL_W = $clog2(WORDS),
  localparam int DATA_W = WORDS * ELEM_W
) (
  input  logic [DATA_W-1:0]              line_data,
  input  logic [LANES-1:0][WSEL_W-1:0]   lane_word,
  output logic [LANES-1:0][ELEM_W-1:0]   picked
);
  logic [WORDS-1:0][ELEM_W-1:0] words;
  assign words = line_data;

  for (genvar i = 0; i < LANES; i++) begin : g_mux
    assign picked[i] = words[lane_word[i]];
  end
endmodule

// File: rtl/gather_seq.sv
module gather_seq
  import gather_pkg::*;
#(
  parameter int LANES      = 16,
  parameter int ADDR_W     = 32,
  parameter int OFF_W      = 16,
  parameter int ELEM_W     = 32,
  parameter int LINE_BYTES = 64,
  localparam int ELEM_SH = $clog2(ELEM_W / 8),
  localparam int LINE_SH = $clog2(LINE_BYTES),
  localparam int LINE_W  = ADDR_W - LINE_SH,
  localparam int WORDS   = LINE_BYTES / (ELEM_W / 8),
  localparam int WSEL_W  = $clog2(WORDS),
  localparam int EA_W    = ADDR_W - ELEM_SH,
  localparam int DATA_W  = LINE_BYTES * 8,
  localparam int IDX_W   = $clog2(LANES)
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           start,
  input  logic [ADDR_W-1:0]              base_addr,
  input  logic [LANES-1:0][OFF_W-1:0]    offsets,
  input  logic [LANES-1:0]               mask_in,
  input  logic [LANES-1:0][ELEM_W-1:0]   dst_in,
  output logic                           busy,
  output logic                           done,
  output logic                           fault,
  output logic [LANES-1:0]               mask_out,
  output logic [LANES-1:0][ELEM_W-1:0]   dst_out,
  output logic                           req_valid,
  output logic [LINE_W-1:0]              req_line,
  input  logic                           req_ready,
  input  logic [DATA_W-1:0]              rsp_data,
  input  logic                           rsp_fault
);

  // Reset: asserted asynchronously, released after two clock edges.
  logic [1:0] rst_pipe;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign arst_n = rst_pipe[1];

  // State
  gs_state_e                   st_q, st_n;
  logic [LANES-1:0]            mask_q, mask_n;
  logic [LANES-1:0][ELEM_W-1:0] dst_q, dst_n;
  logic                        flt_q, flt_n;
  logic [EA_W-1:0]             base_q;
  logic [LANES-1:0][OFF_W-1:0] offs_q;
  logic                        cap_en, upd_en;

  // Datapath
  logic [LANES-1:0][LINE_W-1:0] lane_line;
  logic [LANES-1:0][WSEL_W-1:0] lane_word;
  logic [IDX_W-1:0]             first_idx;
  logic                         any_pend;
  logic [LINE_W-1:0]            target;
  logic [LANES-1:0]             hit;
  logic [LANES-1:0][ELEM_W-1:0] picked;
  logic                         fire;

  gs_lane_addr #(
    .LANES (LANES),
    .EA_W  (EA_W),
    .OFF_W (OFF_W),
    .WSEL_W(WSEL_W)
  ) u_addr (
    .base_el  (base_q),
    .offs     (offs_q),
    .lane_line(lane_line),
    .lane_word(lane_word)
  );

  gs_first_lane #(.LANES(LANES)) u_first (
    .pend     (mask_q),
    .first_idx(first_idx),
    .any_pend (any_pend)
  );

  assign target = lane_line[first_idx];

  gs_line_match #(.LANES(LANES), .LINE_W(LINE_W)) u_match (
    .lane_line(lane_line),
    .target   (target),
    .pend     (mask_q),
    .hit      (hit)
  );

  gs_word_pick #(.LANES(LANES), .ELEM_W(ELEM_W), .WORDS(WORDS)) u_pick (
    .line_data(rsp_data),
    .lane_word(lane_word),
    .picked   (picked)
  );

  assign req_valid = (st_q == GS_RUN) & any_pend;
  assign req_line  = target;
  assign fire      = req_valid & req_ready;

  // Next state
  always_comb begin
    st_n   = st_q;
    mask_n = mask_q;
    dst_n  = dst_q;
    flt_n  = flt_q;
    cap_en = 1'b0;
    upd_en = 1'b0;
    unique case (st_q)
      GS_IDLE: begin
        if (start) begin
          cap_en = 1'b1;
          upd_en = 1'b1;
          mask_n = mask_in;
          dst_n  = dst_in;
          flt_n  = 1'b0;
          st_n   = (|mask_in) ? GS_RUN : GS_FIN;
        end
      end
      GS_RUN: begin
        if (fire) begin
          upd_en = 1'b1;
          if (rsp_fault) begin
            flt_n = 1'b1;
            st_n  = GS_FIN;
          end else begin
            mask_n = mask_q & ~hit;
            for (int i = 0; i < LANES; i++) begin
              if (hit[i]) dst_n[i] = picked[i];
            end
            if (mask_n == '0) st_n = GS_FIN;
          end
        end
      end
      GS_FIN:  st_n = GS_IDLE;
      default: st_n = GS_IDLE;
    endcase
  end

  // Control and result registers
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      st_q   <= GS_IDLE;
      mask_q <= '0;
      dst_q  <= '0;
      flt_q  <= 1'b0;
    end else begin
      st_q <= st_n;
      if (upd_en) begin
        mask_q <= mask_n;
        dst_q  <= dst_n;
        flt_q  <= flt_n;
      end
    end
  end

  // Operand capture, no reset needed
  always_ff @(posedge clk) begin
    if (cap_en) begin
      base_q <= base_addr[ADDR_W-1:ELEM_SH];
      offs_q <= offsets;
    end
  end

  assign busy     = (st_q == GS_RUN);
  assign done     = (st_q == GS_FIN);
  assign fault    = flt_q & done;
  assign mask_out = mask_q;
  assign dst_out  = dst_q;

endmodule

// File: rtl/gather_seq_chk.sv
module gather_seq_chk #(
  parameter int LANES   = 16,
  parameter int ADDR_W  = 32,
  parameter int LINE_W  = 26,
  parameter int ELEM_SH = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] base_addr,
  input logic [LANES-1:0]  mask_in,
  input logic              busy,
  input logic              done,
  input logic              fault,
  input logic [LANES-1:0]  mask_out,
  input logic              req_valid,
  input logic [LINE_W-1:0] req_line,
  input logic              req_ready,
  input logic              rsp_fault
);
  AST_REQ_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> busy); // R11
  AST_BUSY_DONE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done)); // R11
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_line))); // R10
  AST_MASK_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> ((mask_out & ~$past(mask_out)) == '0)); // R4
  AST_CLEAN_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !fault) |-> (mask_out == '0)); // R6
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_FAULT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && rsp_fault) |=> (done && fault && $stable(mask_out))); // R7
  AST_EMPTY_QUICK: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done && mask_in == '0) |=> (done && !req_valid)); // R9
  AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !done) |-> (base_addr[ELEM_SH-1:0] == '0)); // R2
endmodule

bind gather_seq gather_seq_chk #(
  .LANES  (LANES),
  .ADDR_W (ADDR_W),
  .LINE_W (LINE_W),
  .ELEM_SH(ELEM_SH)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .start    (start),
  .base_addr(base_addr),
  .mask_in  (mask_in),
  .busy     (busy),
  .done     (done),
  .fault    (fault),
  .mask_out (mask_out),
  .req_valid(req_valid),
  .req_line (req_line),
  .req_ready(req_ready),
  .rsp_fault(rsp_fault)
);

// File: tb/gather_seq_test.sv
`timescale 1ns/1ps
module gather_seq_test;
  localparam int LANES  = 16;
  localparam int OFF_W  = 16;
  localparam int ELEM_W = 32;
  localparam int LINE_W = 26;
  localparam int DATA_W = 512;
  localparam logic [31:0] KEY = 32'hC3A5_1E00;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic                          rst_n;
  logic                          start;
  logic [31:0]                   base_addr;
  logic [LANES-1:0][OFF_W-1:0]   offsets;
  logic [LANES-1:0]              mask_in;
  logic [LANES-1:0][ELEM_W-1:0]  dst_in;
  logic                          busy, done, fault;
  logic [LANES-1:0]              mask_out;
  logic [LANES-1:0][ELEM_W-1:0]  dst_out;
  logic                          req_valid;
  logic [LINE_W-1:0]             req_line;
  logic                          req_ready;
  logic [DATA_W-1:0]             rsp_data;
  logic                          rsp_fault;

  logic              flt_en;
  logic [LINE_W-1:0] flt_line;

  gather_seq uut (
    .clk(clk), .rst_n(rst_n), .start(start), .base_addr(base_addr),
    .offsets(offsets), .mask_in(mask_in), .dst_in(dst_in),
    .busy(busy), .done(done), .fault(fault), .mask_out(mask_out),
    .dst_out(dst_out), .req_valid(req_valid), .req_line(req_line),
    .req_ready(req_ready), .rsp_data(rsp_data), .rsp_fault(rsp_fault)
  );

  // Memory model: word k of line L holds ({L,k,00} ^ KEY)
  always_comb begin
    for (int k = 0; k < 16; k++) rsp_data[32*k +: 32] = {req_line, 4'(k), 2'b00} ^ KEY;
    rsp_fault = flt_en && (req_line == flt_line);
  end

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] rng = 32'h1234_5678;

  logic [LANES-1:0]             m_mask;
  logic [LANES-1:0][ELEM_W-1:0] m_dst;
  bit                           m_fault;
  int                           nreq;

  function automatic logic [31:0] next_rng(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic roll();
    rng = next_rng(rng);
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [LINE_W-1:0] line_of(input logic [31:0] b, input logic [OFF_W-1:0] o);
    logic [31:0] a;
    a = b + {14'b0, o, 2'b00};
    return a[31:6];
  endfunction

  function automatic logic [31:0] elem_of(input logic [31:0] b, input logic [OFF_W-1:0] o);
    return (b + {14'b0, o, 2'b00}) ^ KEY;
  endfunction

  function automatic int distinct_lines(input logic [31:0] b, input logic [LANES-1:0] m);
    int n;
    bit seen;
    n = 0;
    for (int i = 0; i < LANES; i++) begin
      if (m[i]) begin
        seen = 0;
        for (int j = 0; j < i; j++)
          if (m[j] && line_of(b, offsets[j]) == line_of(b, offsets[i])) seen = 1;
        if (!seen) n++;
      end
    end
    return n;
  endfunction

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
  endtask

  // rmode: 0 always ready, 1 alternating, 2 random
  task automatic gather(input logic [31:0] b, input logic [LANES-1:0] msk,
                        input int rmode, input bit poke);
    logic [LINE_W-1:0] prev_line;
    bit                prev_stall;
    bit                pend;
    int                lo;
    int                exp_n;
    @(negedge clk);
    base_addr = b;
    mask_in   = msk;
    start     = 1'b1;
    req_ready = 1'b0;
    m_mask    = msk;
    m_dst     = dst_in;
    m_fault   = 0;
    nreq      = 0;
    exp_n     = distinct_lines(b, msk);
    prev_stall = 0;
    prev_line  = '0;
    pend      = (msk == '0);
    @(negedge clk);
    start = 1'b0;
    for (int cyc = 0; ; cyc++) begin
      if (start) begin
        start     = 1'b0;
        mask_in   = msk;
        base_addr = b;
      end
      roll();
      req_ready = (rmode == 0) ? 1'b1 : (rmode == 1) ? cyc[0] : rng[7];
      #1;
      if (pend) begin
        chk(done === 1'b1, "R6 R7 R9", "done when expected", 64'(done), 64'd1);
        chk(req_valid === 1'b0, "R9 R11", "no request at done", 64'(req_valid), 64'd0);
        break;
      end
      chk(done === 1'b0 && busy === 1'b1, "R11", "busy while pending", {62'd0, busy, done}, 64'd2);
      if (cyc >= 200) begin
        chk(0, "R11", "gather did not finish", 64'(cyc), 64'd0);
        break;
      end
      if (prev_stall)
        chk(req_valid === 1'b1 && req_line == prev_line, "R10", "request held",
            64'(req_line), 64'(prev_line));
      if (req_valid === 1'b1 && req_ready) begin
        lo = -1;
        for (int i = LANES - 1; i >= 0; i--) if (m_mask[i]) lo = i;
        if (lo < 0) chk(0, "R3", "request with nothing pending", 64'(req_line), 64'd0);
        else chk(req_line == line_of(b, offsets[lo]), "R3", "line of lowest lane",
                 64'(req_line), 64'(line_of(b, offsets[lo])));
        nreq++;
        if (flt_en && req_line == flt_line) begin
          m_fault = 1;
          pend    = 1;
        end else begin
          for (int i = 0; i < LANES; i++) begin
            if (m_mask[i] && line_of(b, offsets[i]) == req_line) begin
              m_mask[i] = 1'b0;
              m_dst[i]  = elem_of(b, offsets[i]);
            end
          end
          if (m_mask == '0) pend = 1;
        end
      end
      prev_stall = (req_valid === 1'b1) && !req_ready;
      prev_line  = req_line;
      if (poke && cyc == 1 && busy) begin
        start     = 1'b1;
        mask_in   = ~msk;
        base_addr = b + 32'h40;
      end
      @(negedge clk);
    end
    chk(fault === m_fault, "R7", "fault flag", 64'(fault), 64'(m_fault));
    chk(mask_out === m_mask, "R6 R7", "returned mask", 64'(mask_out), 64'(m_mask));
    for (int i = 0; i < LANES; i++)
      chk(dst_out[i] === m_dst[i], "R2 R4 R5", $sformatf("dst lane %0d", i),
          64'(dst_out[i]), 64'(m_dst[i]));
    if (!m_fault) chk(nreq == exp_n, "R4", "one request per line", 64'(nreq), 64'(exp_n));
    @(negedge clk);
    #1;
    chk(done === 1'b0, "R6", "done is a single pulse", 64'(done), 64'd0);
  endtask

  // Global watchdog
  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [31:0]      b;
    logic [LANES-1:0] m, rem;
    rst_n = 1'b0; start = 1'b0; base_addr = '0; offsets = '0; mask_in = '0;
    dst_in = '0; req_ready = 1'b0; flt_en = 1'b0; flt_line = '0;
    repeat (3) @(negedge clk);
    #1;
    chk(busy === 0 && done === 0 && fault === 0 && req_valid === 0, "R11", "reset outputs",
        {60'd0, busy, done, fault, req_valid}, 64'd0);
    chk(mask_out === '0, "R11", "reset mask", 64'(mask_out), 64'd0);
    chk(dst_out === '0, "R11", "reset dst", 64'(dst_out[0]), 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R9: empty mask
    for (int i = 0; i < LANES; i++) dst_in[i] = 32'hE000_0000 + i;
    gather(32'h0000_1000, '0, 0, 0);
    chk(nreq == 0, "R9", "no request for empty mask", 64'(nreq), 64'd0);

    // R4: all lanes share one line -> one request
    for (int i = 0; i < LANES; i++) offsets[i] = OFF_W'(15 - i);
    gather(32'h0000_2000, '1, 0, 0);
    chk(nreq == 1, "R4", "shared line single request", 64'(nreq), 64'd1);

    // R3: every lane its own line, reversed order
    for (int i = 0; i < LANES; i++) offsets[i] = OFF_W'((15 - i) * 16);
    gather(32'h0001_0004, 16'hA5F3, 1, 0);

    // R1: start pulsed while busy is ignored
    for (int i = 0; i < LANES; i++) offsets[i] = OFF_W'(i * 5);
    gather(32'h0000_3008, 16'h7BCD, 2, 1);

    // Address wrap, R2
    for (int i = 0; i < LANES; i++) offsets[i] = OFF_W'(i * 7);
    gather(32'hFFFF_FFC4, '1, 0, 0);

    // Sweep with faults and reissue
    for (int t = 0; t < 300; t++) begin
      roll(); b = {rng[31:2], 2'b00};
      for (int i = 0; i < LANES; i++) begin
        roll();
        offsets[i] = (t % 4 == 0) ? rng[15:0] : {10'd0, rng[5:0]};
        dst_in[i]  = {16'(t), 16'(i)};
      end
      roll(); m = rng[15:0];
      roll();
      flt_en   = (t % 3 != 2);
      flt_line = line_of(b, offsets[rng[3:0]]);
      gather(b, m, t % 3, (t % 7 == 0));
      if (m_fault) begin
        rem    = mask_out;
        dst_in = dst_out;
        flt_en = 1'b0;
        gather(b, rem, (t + 1) % 3, 0);
        chk(nreq == distinct_lines(b, rem), "R8", "reissue requests only remaining lines",
            64'(nreq), 64'(distinct_lines(b, rem)));
        chk(mask_out === '0 && fault === 1'b0, "R8", "reissue completes",
            64'(mask_out), 64'd0);
      end
    end

    summary();
    $finish;
  end
endmodule